// File: doc/BRIEF.md
# ATM Receive-Side Cell Source (PHY Slave)

This block sits on the PHY side of a UTOPIA receive-direction link and hands 53-byte ATM cells to an external ATM-layer master. A cell buffer that is not part of this block shows the current head byte and a flag saying that at least one complete, not yet started cell is waiting. The block pops bytes from that buffer one at a time and puts each one on an 8-bit bus. It marks the first byte of each cell with a start-of-cell flag and drives a cell-available flag that the master reads when it polls.

The block supports two modes, chosen by a mode input. In single-PHY mode it is the only slave on the link, so the cell-available flag is always driven. In multi-PHY mode the block decodes only one active-low address bit. The output enable of the cell-available flag is that bit delayed by one clock, so several of these blocks can share one bus with no glue logic. Each block is tied to a different bit of the 5-bit address, so five blocks answer to 0Fh, 17h, 1Bh, 1Dh and 1Eh. The tristate outputs are given as separate value and output-enable signals.

Top module: `cell_src_top`

## Requirements
- R1: After synchronous active-low reset, the data and start-of-cell enables are 0, the start-of-cell flag is 0, fifo_pop is 0, and the next transfer begins a new cell.
- R2: soc_out is 1 with the first byte of each 53-byte cell and 0 with the other 52 bytes.
- R3: data_oe and soc_oe are 1 only in a cycle in which a transferred byte is on data_out. In every other cycle they are 0.
- R4: With mphy_mode=0 (single-PHY), clav_oe is always 1.
- R5: With mphy_mode=1 (multi-PHY), clav_oe in each cycle equals the inverse of addr_n sampled at the previous clock edge. Driving addr_n low on this block's address bit selects it.
- R6: clav_out is 1 while a complete cell is waiting or a cell is partly read. It stays 1 through the read and falls in the cycle after the last byte is taken, if no further cell is waiting.
- R7: When rd_en_n is sampled low at an edge and a transfer is allowed, the byte popped at that edge appears on data_out in the following cycle. Bytes come out in buffer order, with exactly one fifo_pop per byte.
- R8: In multi-PHY mode a transfer is allowed only if addr_n was low at the last edge at which rd_en_n was high. Otherwise the outputs stay disabled and no byte is popped.
- R9: If rd_en_n goes high partway through a cell, the byte position holds. When enable returns, the transfer resumes at the next byte, without a start-of-cell flag.
- R10: With no cell waiting and no cell partly read, a low rd_en_n is ignored: no pop, and the enables stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mphy_mode | input | 1 | 0 = single-PHY, 1 = multi-PHY |
| rd_en_n | input | 1 | Active-low read enable from the master |
| addr_n | input | 1 | Active-low address bit for this block |
| fifo_cell_rdy | input | 1 | At least one complete, unstarted cell is buffered |
| fifo_data | input | 8 | Head byte of the cell buffer |
| fifo_pop | output | 1 | Takes the head byte at this edge |
| data_out | output | 8 | Cell byte bus value |
| data_oe | output | 1 | Output enable for data_out |
| soc_out | output | 1 | Start-of-cell flag value |
| soc_oe | output | 1 | Output enable for soc_out |
| clav_out | output | 1 | Cell-available flag value |
| clav_oe | output | 1 | Output enable for clav_out |

## Verification
The byte, the start-of-cell flag and the data enables are due one edge after rd_en_n is sampled low. clav_oe in multi-PHY mode is due one edge after addr_n is sampled. clav_out follows the pointer and the buffer flag in the same cycle as the edge that changes them. The bench changes its inputs 2 ns after a rising edge, takes one edge, and samples 2 ns after that edge, so each check reads exactly the cycle that follows the stimulus. A free-running bench model of the buffer counts pops, which gives the expected byte values independently of the design.

// File: rtl/cell_src_pkg.sv
// Shared constants and types for the receive-side cell source.
// Assumes standard 53-byte ATM cells and an 8-bit bus.
package cell_src_pkg;
    localparam int CELL_BYTES_DEF = 53;
    localparam int BUS_W_DEF      = 8;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_MULTI  = 1'b1
    } phy_mode_e;
endpackage

// File: rtl/cell_src_sel.sv
// Selection tracker for multi-PHY mode.
// Records whether this block was addressed at the last edge where the read
// enable was inactive. That value holds while the enable stays active.
// Assumes the master presents the address the cycle before asserting enable.
module cell_src_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en_n,
    input  logic addr_n,
    output logic selected
);
    // Capture the address while enable is idle, then freeze it during a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       selected <= 1'b0;
        else if (rd_en_n) selected <= ~addr_n;
    end

    // R8
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_n && !$past(rd_en_n)) |=> $stable(selected) || $past(rd_en_n));
endmodule

// File: rtl/cell_src_clav.sv
// Cell-available flag and its output enable.
// The flag is high while a cell is waiting or is partly read. The enable is
// always on in single-PHY mode. In multi-PHY mode it follows the address bit
// delayed by one clock.
module cell_src_clav (
    input  logic clk,
    input  logic rst_n,
    input  logic mphy_mode,
    input  logic addr_n,
    input  logic mid_cell,
    input  logic fifo_cell_rdy,
    output logic clav_out,
    output logic clav_oe
);
    import cell_src_pkg::*;

    logic addr_seen_q;

    // Delay the decoded address bit by one clock for the poll response.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_seen_q <= 1'b0;
        else        addr_seen_q <= ~addr_n;
    end

    // Select the enable source from the mode.
    always_comb begin
        clav_oe = (phy_mode_e'(mphy_mode) == MODE_SINGLE) ? 1'b1 : addr_seen_q;
    end

    // Available while a cell is in flight or another one is queued.
    always_comb begin
        clav_out = mid_cell | fifo_cell_rdy;
    end

    // R5
    poll_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mphy_mode && $past(rst_n)) |-> (clav_oe == !$past(addr_n)));
endmodule

// File: rtl/cell_src_seq.sv
// Byte sequencer: walks the byte position through a cell and registers the
// bus value, start-of-cell flag and enables. The position holds while
// advance is low, so a paused cell resumes where it stopped.
// Assumes advance is asserted only when a byte is really available.
module cell_src_seq #(
    parameter int CELL_BYTES = cell_src_pkg::CELL_BYTES_DEF,
    parameter int BUS_W      = cell_src_pkg::BUS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [BUS_W-1:0] byte_in,
    output logic             mid_cell,
    output logic [BUS_W-1:0] data_out,
    output logic             soc_out,
    output logic             out_en
);
    localparam int PTR_W = $clog2(CELL_BYTES);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(CELL_BYTES - 1);

    logic [PTR_W-1:0] ptr_q;

    // Step the byte position, wrapping after the last byte of a cell.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (advance) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    // Register the outgoing byte, the start flag and the bus enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            soc_out  <= 1'b0;
            out_en   <= 1'b0;
        end else begin
            out_en  <= advance;
            soc_out <= advance && (ptr_q == '0);
            if (advance) data_out <= byte_in;
        end
    end

    // A cell is in flight whenever the position is past its first byte.
    always_comb begin
        mid_cell = (ptr_q != '0);
    end

    // R9
    hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q));
    // R2
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);
endmodule

// File: rtl/cell_src_top.sv
// Receive-side cell source, the PHY slave of a UTOPIA-style link.
// It decides when a byte may move, feeds the sequencer and exposes the
// tristate outputs as value/enable pairs. The cell buffer is external.
module cell_src_top #(
    parameter int CELL_BYTES = cell_src_pkg::CELL_BYTES_DEF,
    parameter int BUS_W      = cell_src_pkg::BUS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mphy_mode,
    input  logic             rd_en_n,
    input  logic             addr_n,
    input  logic             fifo_cell_rdy,
    input  logic [BUS_W-1:0] fifo_data,
    output logic             fifo_pop,
    output logic [BUS_W-1:0] data_out,
    output logic             data_oe,
    output logic             soc_out,
    output logic             soc_oe,
    output logic             clav_out,
    output logic             clav_oe
);
    logic selected;
    logic mid_cell;
    logic permitted;

    cell_src_sel i_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_n  (rd_en_n),
        .addr_n   (addr_n),
        .selected (selected)
    );

    cell_src_clav i_clav (
        .clk           (clk),
        .rst_n         (rst_n),
        .mphy_mode     (mphy_mode),
        .addr_n        (addr_n),
        .mid_cell      (mid_cell),
        .fifo_cell_rdy (fifo_cell_rdy),
        .clav_out      (clav_out),
        .clav_oe       (clav_oe)
    );

    // Gate the read: this block must be enabled, selected (multi-PHY only) and
    // have a cell in flight or waiting.
    always_comb begin
        permitted = !mphy_mode || selected;
        fifo_pop  = !rd_en_n && permitted && (mid_cell || fifo_cell_rdy);
    end

    cell_src_seq #(.CELL_BYTES(CELL_BYTES), .BUS_W(BUS_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (fifo_pop),
        .byte_in  (fifo_data),
        .mid_cell (mid_cell),
        .data_out (data_out),
        .soc_out  (soc_out),
        .out_en   (data_oe)
    );

    // The start flag shares its enable with the data bus.
    always_comb begin
        soc_oe = data_oe;
    end

    // R3
    soc_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soc_out |-> data_oe);
    // R7
    oe_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(!rd_en_n));
    // R10
    pop_needs_clav_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> clav_out);
    // R4
    single_clav_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mphy_mode |-> clav_oe);
endmodule

// File: tb/test_cell_src_top.sv
module test_cell_src_top;
    localparam int CB = 53;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mphy_mode = 1'b0;
    logic       rd_en_n = 1'b1;
    logic       addr_n = 1'b1;
    logic       fifo_cell_rdy;
    logic [7:0] fifo_data;
    logic       fifo_pop, data_oe, soc_out, soc_oe, clav_out, clav_oe;
    logic [7:0] data_out;

    int tests = 0;
    int fails = 0;
    int pop_total = 0;
    int cells_loaded = 0;
    int cells_started = 0;

    always #4 clk = ~clk;

    // Bench model of the cell buffer: head byte is the running pop count.
    assign fifo_data     = pop_total[7:0];
    assign fifo_cell_rdy = cells_loaded > cells_started;

    always @(posedge clk) begin
        if (fifo_pop) begin
            if (pop_total % CB == 0) cells_started <= cells_started + 1;
            pop_total <= pop_total + 1;
        end
    end

    cell_src_top i_cell_src_top (
        .clk(clk), .rst_n(rst_n), .mphy_mode(mphy_mode), .rd_en_n(rd_en_n),
        .addr_n(addr_n), .fifo_cell_rdy(fifo_cell_rdy), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .data_out(data_out), .data_oe(data_oe),
        .soc_out(soc_out), .soc_oe(soc_oe), .clav_out(clav_out), .clav_oe(clav_oe)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Read n bytes back to back, checking value, flags and enables.
    task automatic read_bytes(int n, int first_pos, string req);
        rd_en_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            int base;
            base = pop_total;
            tick();
            if (data_out != base[7:0] || data_oe !== 1'b1 || soc_oe !== 1'b1 ||
                soc_out !== ((first_pos + i) % CB == 0)) begin
                check({req, " byte"}, 0, 1);
            end
        end
        tests++;
        rd_en_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 data_oe", data_oe, 0);
        check("R1 soc_out", soc_out, 0);
        check("R1 fifo_pop", fifo_pop, 0);
        check("R4 clav_oe", clav_oe, 1);
    endtask

    task automatic t_idle_ignored();
        int p;
        p = pop_total;
        rd_en_n = 1'b0;
        check("R10 pop", fifo_pop, 0);
        tick(); tick();
        check("R10 oe", data_oe, 0);
        check("R10 pops", pop_total, p);
        check("R6 clav idle", clav_out, 0);
        rd_en_n = 1'b1;
        tick();
    endtask

    task automatic t_single_cell();
        int p;
        cells_loaded++;
        #0;
        check("R6 clav ready", clav_out, 1);
        p = pop_total;
        read_bytes(CB - 1, 0, "R2 R7");
        check("R6 clav held", clav_out, 1);
        read_bytes(1, CB - 1, "R7 last");
        check("R6 clav drop", clav_out, 0);
        check("R7 pops", pop_total - p, CB);
        tick();
        check("R3 oe off", data_oe, 0);
        check("R3 soc_oe off", soc_oe, 0);
    endtask

    task automatic t_pause();
        cells_loaded++;
        read_bytes(10, 0, "R9 pre");
        tick();
        check("R9 paused oe", data_oe, 0);
        tick(); tick();
        check("R9 clav", clav_out, 1);
        rd_en_n = 1'b0;
        tick();
        check("R9 resume soc", soc_out, 0);
        check("R9 resume byte", data_out, (pop_total - 1) % 256);
        check("R9 resume pos", (pop_total - 1) % CB, 10);
        read_bytes(CB - 11, 11, "R9 rest");
        tick();
    endtask

    task automatic t_back_to_back();
        cells_loaded += 2;
        read_bytes(CB, 0, "R2 first");
        check("R6 clav next", clav_out, 1);
        rd_en_n = 1'b0;
        tick();
        check("R2 second soc", soc_out, 1);
        read_bytes(CB - 1, 1, "R2 second");
        check("R6 clav empty", clav_out, 0);
        tick();
    endtask

    task automatic t_multi();
        int p;
        mphy_mode = 1'b1;
        addr_n = 1'b0;
        tick();
        check("R5 polled", clav_oe, 1);
        addr_n = 1'b1;
        tick();
        check("R5 not polled", clav_oe, 0);
        cells_loaded++;
        p = pop_total;
        rd_en_n = 1'b0;
        tick(); tick();
        check("R8 unselected oe", data_oe, 0);
        check("R8 unselected pops", pop_total, p);
        rd_en_n = 1'b1;
        addr_n = 1'b0;
        tick();
        addr_n = 1'b1;
        rd_en_n = 1'b0;
        tick();
        check("R8 selected soc", soc_out, 1);
        check("R8 selected oe", data_oe, 1);
        read_bytes(CB - 1, 1, "R8 rest");
        check("R8 pops", pop_total - p, CB);
        tick();
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        t_reset();
        t_idle_ignored();
        t_single_cell();
        t_pause();
        t_back_to_back();
        t_multi();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule